// File: doc/BRIEF.md
# Flash Program/Erase Timing Sequencer

This block produces the timed control pulses that a flash array macro needs for a program or a segment erase. A divider, set at run time, derives a slow timing clock from the system clock, and every operation is counted in periods of that slow clock. A program of one byte or word lasts a fixed number of periods. Within that window the high-voltage enable is held for a shorter centred stretch, so the array sees the programming stress only for the time it needs. A segment erase lasts a configurable number of periods.

The CPU side sees a simple handshake. It raises a one-cycle program or erase request. The block raises busy until the operation ends, then pulses done for one system clock. Before any operation starts, the divider setting is checked against the legal band of the timing clock, 257 kHz to 476 kHz. An illegal setting raises a fault and requests are refused. A request that arrives while an operation runs is dropped and sets a sticky violation flag.

Erase always returns a whole segment to all ones, while programming can only clear bits. For this reason the block reports the byte span of the segment being erased, so that the array side clears the right amount.

Top module: `flash_timing_seq`

## Requirements
- R1: `clk_fault_o` is high exactly when SYS_CLK_HZ/(div_i+1) is outside 257000..476000 Hz. With a 50 MHz system clock the legal settings are div_i = 105..193.
- R2: While `clk_fault_o` is high, an idle block ignores requests: busy, done and the strobes stay low.
- R3: A program with `profile_i`=0 keeps `busy_o` and `prog_strobe_o` high for 35·(div+1) system clocks. `erase_strobe_o` stays low.
- R4: In profile 0, `hv_en_o` is high for 29·(div+1) clocks and rises 3·(div+1) clocks after busy rises. The setup is (35−29)/2 timing periods.
- R5: A program with `profile_i`=1 lasts 30·(div+1) clocks. `hv_en_o` is high for 27·(div+1) of them and starts after 1·(div+1) clocks.
- R6: An erase keeps `busy_o` and `erase_strobe_o` high for ERASE_FTG_CYC·(div+1) clocks. `hv_en_o` is high for (ERASE_FTG_CYC−2)·(div+1) clocks and starts after one period.
- R7: During an erase, `seg_bytes_o` is 512 when `seg_info_i`=0 and INFO_SEG_BYTES (default 128) when `seg_info_i`=1. Outside an erase it is 0.
- R8: `done_o` is high for exactly one clock, the first clock in which `busy_o` is low again after an operation.
- R9: A request that arrives while busy is ignored: the running operation keeps its length. It also sets `acv_o`.
- R10: `acv_o` stays set until `acv_clr_i` is high. If a busy-time request and the clear come in the same cycle, the flag stays set.
- R11: If `erase_req_i` and `prog_req_i` are both high while idle, the erase is started.
- R12: `div_i` and `profile_i` are captured when a request is accepted. Changing them during an operation does not alter its timing.
- R13: In reset, `busy_o`, `done_o`, `hv_en_o`, both strobes, `seg_bytes_o` and `acv_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | DIV_W | Timing clock divider; the period is div_i+1 system clocks |
| profile_i | input | 1 | Program timing profile: 0 = 35/29, 1 = 30/27 periods |
| prog_req_i | input | 1 | Start a byte/word program |
| erase_req_i | input | 1 | Start a segment erase |
| seg_info_i | input | 1 | Erase target: 0 = main segment, 1 = information segment |
| acv_clr_i | input | 1 | Write-one-to-clear for the access violation flag |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hv_en_o | output | 1 | High-voltage enable to the array |
| prog_strobe_o | output | 1 | Program phase active |
| erase_strobe_o | output | 1 | Erase phase active |
| seg_bytes_o | output | 10 | Byte span of the segment under erase |
| clk_fault_o | output | 1 | Divider gives an out-of-range timing clock |
| acv_o | output | 1 | Sticky access violation flag |

## Verification
The assertions assume that requests and the clear input are synchronous single-cycle levels sampled at the clock edge. They also assume that the divider input is settled in the cycle a request is accepted, because the range check looks at it live. The bench drives every input on the falling edge, pulses each request for one cycle, and changes the divider in the middle of an operation only on purpose, to show that the captured copy rules. Measurements are made by counting falling-edge samples of busy, the high-voltage enable and the strobes, and those counts are compared against period multiples worked out from the profile constants.

// File: rtl/fts_pkg.sv
package fts_pkg;

    localparam int unsigned FTG_MIN_HZ     = 257_000;
    localparam int unsigned FTG_MAX_HZ     = 476_000;
    localparam int unsigned MAIN_SEG_BYTES = 512;
    localparam int unsigned SEG_BYTES_W    = 10;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } op_e;

    typedef struct packed {
        logic [7:0] total;
        logic [7:0] hv;
    } prog_prof_t;

    localparam prog_prof_t PROF_A = '{total: 8'd35, hv: 8'd29};
    localparam prog_prof_t PROF_B = '{total: 8'd30, hv: 8'd27};

    function automatic prog_prof_t pick_profile(input logic sel);
        return sel ? PROF_B : PROF_A;
    endfunction

    // smallest divider value whose timing clock is not above the upper limit
    function automatic int unsigned min_div(input longint unsigned sys_hz);
        longint unsigned q;
        q = (sys_hz + longint'(FTG_MAX_HZ) - 1) / longint'(FTG_MAX_HZ);
        return 32'(q) - 1;
    endfunction

    // largest divider value whose timing clock is not below the lower limit
    function automatic int unsigned max_div(input longint unsigned sys_hz);
        longint unsigned q;
        q = sys_hz / longint'(FTG_MIN_HZ);
        return 32'(q) - 1;
    endfunction

endpackage

// File: rtl/fts_range_chk.sv
module fts_range_chk
    import fts_pkg::*;
#(
    parameter longint unsigned SYS_CLK_HZ = 50_000_000,
    parameter int unsigned     DIV_W      = 8
)(
    input  logic [DIV_W-1:0] div_i,
    output logic             fault_o
);
    localparam int unsigned DIV_LO = min_div(SYS_CLK_HZ);
    localparam int unsigned DIV_HI = max_div(SYS_CLK_HZ);

    assign fault_o = (32'(div_i) < DIV_LO) || (32'(div_i) > DIV_HI);
endmodule

// File: rtl/fts_ftg_div.sv
module fts_ftg_div #(
    parameter int unsigned DIV_W = 8
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            phase_q <= '0;
        end else if (phase_q == div_i) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick_o = run_i && (phase_q == div_i);
endmodule

// File: rtl/fts_window.sv
module fts_window #(
    parameter int unsigned KW = 7
)(
    input  logic          active_i,
    input  logic [KW-1:0] k_i,
    input  logic [KW-1:0] start_i,
    input  logic [KW-1:0] len_i,
    output logic          hv_o
);
    logic [KW-1:0] stop;

    assign stop = start_i + len_i;
    assign hv_o = active_i && (k_i >= start_i) && (k_i < stop);
endmodule

// File: rtl/flash_timing_seq.sv
module flash_timing_seq
    import fts_pkg::*;
#(
    parameter longint unsigned SYS_CLK_HZ     = 50_000_000,
    parameter int unsigned     DIV_W          = 8,
    parameter int unsigned     ERASE_FTG_CYC  = 40,
    parameter int unsigned     INFO_SEG_BYTES = 128
)(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [DIV_W-1:0]       div_i,
    input  logic                   profile_i,
    input  logic                   prog_req_i,
    input  logic                   erase_req_i,
    input  logic                   seg_info_i,
    input  logic                   acv_clr_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic                   hv_en_o,
    output logic                   prog_strobe_o,
    output logic                   erase_strobe_o,
    output logic [SEG_BYTES_W-1:0] seg_bytes_o,
    output logic                   clk_fault_o,
    output logic                   acv_o
);
    localparam int unsigned MAX_CYC = (ERASE_FTG_CYC > 35) ? ERASE_FTG_CYC : 35;
    localparam int unsigned KW      = $clog2(MAX_CYC + 1) + 1;
    localparam int unsigned INFO_SZ = (INFO_SEG_BYTES <= 64) ? 64 : 128;

    logic                   busy_q, done_q, acv_q;
    op_e                    op_q;
    logic [DIV_W-1:0]       div_q;
    prog_prof_t             prof_q;
    logic [KW-1:0]          k_q;
    logic [SEG_BYTES_W-1:0] seg_q;

    logic          fault, tick, take_erase, take_prog, last_k;
    logic [KW-1:0] len_cyc, win_start, win_len;

    fts_range_chk #(.SYS_CLK_HZ(SYS_CLK_HZ), .DIV_W(DIV_W)) u_range (
        .div_i   (div_i),
        .fault_o (fault)
    );

    fts_ftg_div #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .run_i  (busy_q),
        .div_i  (div_q),
        .tick_o (tick)
    );

    // erase wins when both requests arrive together
    assign take_erase = !busy_q && !fault && erase_req_i;
    assign take_prog  = !busy_q && !fault && prog_req_i && !erase_req_i;

    always_comb begin
        if (op_q == OP_ERASE) begin
            len_cyc   = KW'(ERASE_FTG_CYC);
            win_start = KW'(1);
            win_len   = KW'(ERASE_FTG_CYC - 2);
        end else begin
            len_cyc   = KW'(prof_q.total);
            win_start = KW'((prof_q.total - prof_q.hv) >> 1);
            win_len   = KW'(prof_q.hv);
        end
    end

    assign last_k = (k_q == len_cyc - KW'(1));

    fts_window #(.KW(KW)) u_win (
        .active_i (busy_q),
        .k_i      (k_q),
        .start_i  (win_start),
        .len_i    (win_len),
        .hv_o     (hv_en_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            op_q   <= OP_IDLE;
            div_q  <= '0;
            prof_q <= PROF_A;
            k_q    <= '0;
            seg_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (take_erase || take_prog) begin
                busy_q <= 1'b1;
                op_q   <= take_erase ? OP_ERASE : OP_PROG;
                div_q  <= div_i;
                prof_q <= pick_profile(profile_i);
                k_q    <= '0;
                if (take_erase) begin
                    seg_q <= seg_info_i ? SEG_BYTES_W'(INFO_SZ) : SEG_BYTES_W'(MAIN_SEG_BYTES);
                end else begin
                    seg_q <= '0;
                end
            end else if (busy_q && tick) begin
                if (last_k) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    op_q   <= OP_IDLE;
                    seg_q  <= '0;
                    k_q    <= '0;
                end else begin
                    k_q <= k_q + KW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acv_q <= 1'b0;
        end else if (busy_q && (prog_req_i || erase_req_i)) begin
            acv_q <= 1'b1;
        end else if (acv_clr_i) begin
            acv_q <= 1'b0;
        end
    end

    assign busy_o         = busy_q;
    assign done_o         = done_q;
    assign acv_o          = acv_q;
    assign clk_fault_o    = fault;
    assign seg_bytes_o    = seg_q;
    assign prog_strobe_o  = busy_q && (op_q == OP_PROG);
    assign erase_strobe_o = busy_q && (op_q == OP_ERASE);

    // R2: an idle block with a bad divider does not start
    a_r2_fault_blocks: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && clk_fault_o) |=> !busy_o);

    // R8: done is a single pulse following the end of busy
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(busy_o) && !busy_o));

    // R9: request while busy raises the violation flag
    a_r9_acv_on_busy_req: assert property (@(posedge clk) disable iff (rst)
        (busy_o && (prog_req_i || erase_req_i)) |=> acv_o);

    // R10: flag holds until cleared
    a_r10_acv_sticky: assert property (@(posedge clk) disable iff (rst)
        (acv_o && !acv_clr_i) |=> acv_o);

    // R12: captured profile does not change within an operation
    a_r12_prof_held: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(prof_q));

    // R6: high voltage never outlasts the operation strobe
    a_r6_hv_in_op: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> !hv_en_o);
endmodule

// File: tb/flash_timing_seq_tb_top.sv
module flash_timing_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] div_i = 8'd105;
    logic       profile_i = 1'b0, prog_req_i = 1'b0, erase_req_i = 1'b0;
    logic       seg_info_i = 1'b0, acv_clr_i = 1'b0;
    logic       busy_o, done_o, hv_en_o, prog_strobe_o, erase_strobe_o, clk_fault_o, acv_o;
    logic [9:0] seg_bytes_o;

    int n_chk = 0, n_err = 0;
    int n_busy, n_hv, n_ps, n_es, first_hv, seg_first, done_now, done_after;
    bit timed_out;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    flash_timing_seq dut_i (
        .clk(clk), .rst(rst), .div_i(div_i), .profile_i(profile_i),
        .prog_req_i(prog_req_i), .erase_req_i(erase_req_i), .seg_info_i(seg_info_i),
        .acv_clr_i(acv_clr_i), .busy_o(busy_o), .done_o(done_o), .hv_en_o(hv_en_o),
        .prog_strobe_o(prog_strobe_o), .erase_strobe_o(erase_strobe_o),
        .seg_bytes_o(seg_bytes_o), .clk_fault_o(clk_fault_o), .acv_o(acv_o)
    );

    typedef struct packed {
        logic       er;
        logic [7:0] dv;
        logic       pf;
        logic       inf;
        logic [7:0] n;
        logic [7:0] hv;
        logic [7:0] st;
        logic [9:0] seg;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{er:1'b0, dv:8'd105, pf:1'b0, inf:1'b0, n:8'd35, hv:8'd29, st:8'd3, seg:10'd0},
        '{er:1'b0, dv:8'd193, pf:1'b0, inf:1'b0, n:8'd35, hv:8'd29, st:8'd3, seg:10'd0},
        '{er:1'b0, dv:8'd105, pf:1'b1, inf:1'b0, n:8'd30, hv:8'd27, st:8'd1, seg:10'd0},
        '{er:1'b0, dv:8'd150, pf:1'b1, inf:1'b1, n:8'd30, hv:8'd27, st:8'd1, seg:10'd0},
        '{er:1'b1, dv:8'd120, pf:1'b0, inf:1'b0, n:8'd40, hv:8'd38, st:8'd1, seg:10'd512},
        '{er:1'b1, dv:8'd105, pf:1'b1, inf:1'b1, n:8'd40, hv:8'd38, st:8'd1, seg:10'd128}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // mid: 0 none, 1 change div/profile, 2 busy-time request, 3 request plus clear
    task automatic run_op(input bit er, input bit pr, input int dv, input bit pf,
                          input bit inf, input int mid);
        int guard;
        @(negedge clk);
        div_i = 8'(dv); profile_i = pf; seg_info_i = inf;
        erase_req_i = er; prog_req_i = pr;
        @(negedge clk);
        erase_req_i = 1'b0; prog_req_i = 1'b0;
        n_busy = 0; n_hv = 0; n_ps = 0; n_es = 0; first_hv = -1;
        seg_first = int'(seg_bytes_o); guard = 0; timed_out = 1'b0;
        while (busy_o && guard < 20000) begin
            if (hv_en_o && first_hv < 0) first_hv = n_busy;
            n_busy++;
            if (hv_en_o) n_hv++;
            if (prog_strobe_o) n_ps++;
            if (erase_strobe_o) n_es++;
            if (n_busy == 10) begin
                if (mid == 1) begin div_i = 8'd193; profile_i = ~pf; end
                if (mid >= 2) begin prog_req_i = 1'b1; erase_req_i = 1'b1; end
                if (mid == 3) acv_clr_i = 1'b1;
            end else if (n_busy == 11) begin
                prog_req_i = 1'b0; erase_req_i = 1'b0; acv_clr_i = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        if (guard >= 20000) timed_out = 1'b1;
        done_now = int'(done_o);
        @(negedge clk);
        done_after = int'(done_o);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 busy", int'(busy_o), 0);
        chk("R13 done", int'(done_o), 0);
        chk("R13 hv", int'(hv_en_o), 0);
        chk("R13 strobes", int'(prog_strobe_o) + int'(erase_strobe_o), 0);
        chk("R13 seg", int'(seg_bytes_o), 0);
        chk("R13 acv", int'(acv_o), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // table walk: R3..R8
        for (int i = 0; i < 6; i++) begin
            int d1;
            d1 = int'(VECS[i].dv) + 1;
            tag = VECS[i].er ? "R6" : (VECS[i].pf ? "R5" : "R4");
            run_op(VECS[i].er, !VECS[i].er, int'(VECS[i].dv), VECS[i].pf, VECS[i].inf, 0);
            chk("R8 no timeout", int'(timed_out), 0);
            chk(VECS[i].er ? "R6 busy len" : "R3 busy len", n_busy, int'(VECS[i].n) * d1);
            chk({tag, " hv len"}, n_hv, int'(VECS[i].hv) * d1);
            chk({tag, " hv start"}, first_hv, int'(VECS[i].st) * d1);
            chk("R3 prog strobe", n_ps, VECS[i].er ? 0 : int'(VECS[i].n) * d1);
            chk("R6 erase strobe", n_es, VECS[i].er ? int'(VECS[i].n) * d1 : 0);
            chk("R7 seg span", seg_first, int'(VECS[i].seg));
            chk("R7 seg idle", int'(seg_bytes_o), 0);
            chk("R8 done pulse", done_now, 1);
            chk("R8 done single", done_after, 0);
        end

        // R1 range boundaries
        @(negedge clk); div_i = 8'd104; #1 chk("R1 div 104", int'(clk_fault_o), 1);
        @(negedge clk); div_i = 8'd105; #1 chk("R1 div 105", int'(clk_fault_o), 0);
        @(negedge clk); div_i = 8'd193; #1 chk("R1 div 193", int'(clk_fault_o), 0);
        @(negedge clk); div_i = 8'd194; #1 chk("R1 div 194", int'(clk_fault_o), 1);
        @(negedge clk); div_i = 8'd0;   #1 chk("R1 div 0", int'(clk_fault_o), 1);
        @(negedge clk); div_i = 8'd255; #1 chk("R1 div 255", int'(clk_fault_o), 1);

        // R2 request refused under fault
        @(negedge clk); div_i = 8'd104; prog_req_i = 1'b1; erase_req_i = 1'b1;
        @(negedge clk); prog_req_i = 1'b0; erase_req_i = 1'b0;
        chk("R2 busy", int'(busy_o), 0);
        repeat (3) @(negedge clk);
        chk("R2 done", int'(done_o), 0);
        chk("R2 strobes", int'(prog_strobe_o) + int'(erase_strobe_o), 0);
        chk("R2 acv", int'(acv_o), 0);

        // R11 both requests: erase wins
        run_op(1'b1, 1'b1, 110, 1'b0, 1'b0, 0);
        chk("R11 erase strobe", n_es, 40 * 111);
        chk("R11 prog strobe", n_ps, 0);

        // R12 div/profile changed mid-op
        run_op(1'b0, 1'b1, 105, 1'b0, 1'b0, 1);
        chk("R12 busy len", n_busy, 35 * 106);
        chk("R12 hv len", n_hv, 29 * 106);

        // R9 busy-time request ignored, flag set
        run_op(1'b0, 1'b1, 105, 1'b1, 1'b0, 2);
        chk("R9 busy len", n_busy, 30 * 106);
        chk("R9 no erase", n_es, 0);
        chk("R9 acv set", int'(acv_o), 1);

        // R10 clear, then set-over-clear priority
        repeat (3) @(negedge clk);
        chk("R10 acv held", int'(acv_o), 1);
        acv_clr_i = 1'b1;
        @(negedge clk); acv_clr_i = 1'b0;
        chk("R10 acv cleared", int'(acv_o), 0);
        run_op(1'b0, 1'b1, 105, 1'b0, 1'b0, 3);
        chk("R10 set beats clear", int'(acv_o), 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule